// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for every beat of one SDRAM read or write burst. A controller pulses a start strobe with the first column, the burst length code, the wrap order, and the direction of the access. From the next cycle on, the block presents one column address per enabled clock, together with a valid flag and a flag that marks the final beat.

Fixed bursts stay inside an aligned block of the burst length. The low address bits either count up and wrap, or are XOR-ed with the beat number. A full-page burst walks through every column of the open row and wraps at the page end. It keeps going until a burst-stop or precharge input ends it.

A fresh start is accepted on any cycle and replaces whatever burst is running. A single-write option cuts write bursts to one beat. A clock enable freezes the whole block.

Top module: `sdr_burst_colgen`

## Requirements
- R1: After reset, `col_valid` and `col_last` are 0 until the first accepted start.
- R2: When `start` is high with `ce` high, on the next cycle `col_valid` is 1 and `col_addr` equals that `start_col`.
- R3: The burst length code maps as follows: 3'b000 gives 1 beat, 3'b001 gives 2, 3'b010 gives 4 and 3'b011 gives 8. Codes 3'b100 to 3'b110 are treated as 1 beat. `col_last` is high exactly on the final beat, and `col_valid` is 0 on the enabled cycle after it unless a new start was accepted.
- R4: With `ilv_mode` = 0 and a fixed length BL, beat n has low log2(BL) bits equal to (start low bits + n) mod BL. The upper bits equal those of `start_col`.
- R5: With `ilv_mode` = 1 and a fixed length BL, beat n has low log2(BL) bits equal to the start low bits XOR n. The upper bits are unchanged.
- R6: Code 3'b111 is a full-page burst, in which beat n is (`start_col` + n) mod 2^COL_W. `col_last` is never set, and `ilv_mode` has no effect.
- R7: `burst_stop` or `pre_term` high with `ce` high and no `start` makes `col_valid` 0 on the next cycle.
- R8: A start accepted during a running burst restarts at the new column on the next cycle. A start takes priority over `burst_stop` and `pre_term` in the same cycle.
- R9: When `start_wr` and `single_wr` are both 1 at start, the burst is 1 beat long whatever the length code. Reads, and writes with `single_wr` = 0, keep the coded length.
- R10: While `ce` is 0, `col_addr`, `col_valid` and `col_last` hold, and all other inputs, including `start`, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce | input | 1 | Clock enable; 0 freezes the block |
| start | input | 1 | Begin a new burst |
| start_col | input | COL_W | First column of the burst |
| start_wr | input | 1 | Burst is a write |
| bl_code | input | 3 | Burst length code |
| ilv_mode | input | 1 | 0 sequential, 1 interleaved |
| single_wr | input | 1 | Write bursts are one beat |
| burst_stop | input | 1 | End the running burst |
| pre_term | input | 1 | Precharge ends the running burst |
| col_addr | output | COL_W | Current column address |
| col_valid | output | 1 | `col_addr` holds a burst beat |
| col_last | output | 1 | Final beat of a fixed-length burst |

## Verification
The bench builds the block with COL_W = 6, a 64-column page. With that size a full-page burst started near the top of the page can be run past the page end within a few dozen beats, so the wrap back to column 0 is observed directly. A page of this size still leaves three address bits above the widest fixed burst, so the bench also checks that eight-beat sequential and interleaved bursts never disturb the upper column bits.

// File: rtl/sdr_colgen_pkg.sv
package sdr_colgen_pkg;

    localparam logic [2:0] BLC_ONE   = 3'b000;
    localparam logic [2:0] BLC_TWO   = 3'b001;
    localparam logic [2:0] BLC_FOUR  = 3'b010;
    localparam logic [2:0] BLC_EIGHT = 3'b011;
    localparam logic [2:0] BLC_PAGE  = 3'b111;

    // low-bit mask of a fixed burst (length minus one)
    function automatic logic [2:0] fixed_mask(input logic [2:0] code);
        case (code)
            BLC_TWO:   fixed_mask = 3'd1;
            BLC_FOUR:  fixed_mask = 3'd3;
            BLC_EIGHT: fixed_mask = 3'd7;
            default:   fixed_mask = 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/sdr_bl_decode.sv
module sdr_bl_decode
    import sdr_colgen_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic [2:0]       code,
    input  logic             is_wr,
    input  logic             single_wr,
    output logic [COL_W-1:0] mask,
    output logic             full
);
    logic force_one;

    always_comb begin
        force_one = is_wr && single_wr;
        full      = !force_one && (code == BLC_PAGE);
        if (force_one) begin
            mask = '0;
        end else if (full) begin
            mask = '1;
        end else begin
            mask = {{(COL_W-3){1'b0}}, fixed_mask(code)};
        end
    end
endmodule

// File: rtl/sdr_col_calc.sv
module sdr_col_calc #(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] beat,
    input  logic [COL_W-1:0] mask,
    input  logic             ilv,
    output logic [COL_W-1:0] col
);
    logic [COL_W-1:0] sum;

    assign sum = base + beat;

    for (genvar b = 0; b < COL_W; b++) begin : g_bit
        always_comb begin
            if (!mask[b]) begin
                col[b] = base[b];
            end else if (ilv) begin
                col[b] = base[b] ^ beat[b];
            end else begin
                col[b] = sum[b];
            end
        end
    end
endmodule

// File: rtl/sdr_burst_colgen.sv
module sdr_burst_colgen #(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic             start_wr,
    input  logic [2:0]       bl_code,
    input  logic             ilv_mode,
    input  logic             single_wr,
    input  logic             burst_stop,
    input  logic             pre_term,
    output logic [COL_W-1:0] col_addr,
    output logic             col_valid,
    output logic             col_last
);
    typedef struct packed {
        logic [COL_W-1:0] base;
        logic [COL_W-1:0] beat;
        logic [COL_W-1:0] mask;
        logic             full;
        logic             ilv;
        logic             valid;
        logic             last;
    } burst_st_t;

    burst_st_t        st_d, st_q;
    logic [COL_W-1:0] col_d, col_q;
    logic [COL_W-1:0] dec_mask;
    logic             dec_full;

    sdr_bl_decode #(.COL_W(COL_W)) dec_i (
        .code      (bl_code),
        .is_wr     (start_wr),
        .single_wr (single_wr),
        .mask      (dec_mask),
        .full      (dec_full)
    );

    sdr_col_calc #(.COL_W(COL_W)) calc_i (
        .base (st_d.base),
        .beat (st_d.beat),
        .mask (st_d.mask),
        .ilv  (st_d.ilv),
        .col  (col_d)
    );

    always_comb begin
        st_d = st_q;
        if (ce) begin
            if (start) begin
                st_d.base  = start_col;
                st_d.beat  = '0;
                st_d.mask  = dec_mask;
                st_d.full  = dec_full;
                st_d.ilv   = ilv_mode && !dec_full;
                st_d.valid = 1'b1;
            end else if (burst_stop || pre_term) begin
                st_d.valid = 1'b0;
            end else if (st_q.valid) begin
                if (st_q.last) begin
                    st_d.valid = 1'b0;
                end else begin
                    st_d.beat = st_q.beat + 1'b1;
                end
            end
        end
        st_d.last = st_d.valid && !st_d.full && (st_d.beat == st_d.mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= '0;
            col_q <= '0;
        end else begin
            st_q  <= st_d;
            col_q <= col_d;
        end
    end

    assign col_addr  = col_q;
    assign col_valid = st_q.valid;
    assign col_last  = st_q.last;
endmodule

// File: rtl/sdr_burst_colgen_chk.sv
module sdr_burst_colgen_chk #(
    parameter int COL_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ce,
    input logic             start,
    input logic [COL_W-1:0] start_col,
    input logic             start_wr,
    input logic [2:0]       bl_code,
    input logic             single_wr,
    input logic             burst_stop,
    input logic             pre_term,
    input logic [COL_W-1:0] col_addr,
    input logic             col_valid,
    input logic             col_last
);
    // R1
    last_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        col_last |-> col_valid);

    // R2
    start_loads_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && start) |=> (col_valid && col_addr == $past(start_col)));

    // R3
    last_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && !start && col_last) |=> !col_valid);

    // R6
    page_never_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && start && bl_code == 3'b111 && !(start_wr && single_wr)) |=> !col_last);

    // R7
    terminate_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && !start && (burst_stop || pre_term)) |=> !col_valid);

    // R9
    single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && start && start_wr && single_wr) |=> col_last);

    // R10
    freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> ($stable(col_addr) && $stable(col_valid) && $stable(col_last)));
endmodule

bind sdr_burst_colgen sdr_burst_colgen_chk #(.COL_W(COL_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce         (ce),
    .start      (start),
    .start_col  (start_col),
    .start_wr   (start_wr),
    .bl_code    (bl_code),
    .single_wr  (single_wr),
    .burst_stop (burst_stop),
    .pre_term   (pre_term),
    .col_addr   (col_addr),
    .col_valid  (col_valid),
    .col_last   (col_last)
);

// File: tb/sdr_burst_colgen_tb_top.sv
`timescale 1ns/1ps
module sdr_burst_colgen_tb_top;
    localparam int COL_W = 6;
    localparam int PAGE  = 1 << COL_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ce = 1'b1, start = 1'b0, start_wr = 1'b0, ilv_mode = 1'b0;
    logic             single_wr = 1'b0, burst_stop = 1'b0, pre_term = 1'b0;
    logic [COL_W-1:0] start_col = '0;
    logic [2:0]       bl_code = '0;
    logic [COL_W-1:0] col_addr;
    logic             col_valid, col_last;

    always #2 clk = ~clk;

    sdr_burst_colgen #(.COL_W(COL_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .ce(ce), .start(start), .start_col(start_col),
        .start_wr(start_wr), .bl_code(bl_code), .ilv_mode(ilv_mode),
        .single_wr(single_wr), .burst_stop(burst_stop), .pre_term(pre_term),
        .col_addr(col_addr), .col_valid(col_valid), .col_last(col_last)
    );

    typedef struct packed {
        logic             valid;
        logic             last;
        logic [COL_W-1:0] col;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    n_chk = 0, n_bad = 0;
    bit    done = 0;

    // bench-side burst model, written from the requirements
    bit m_act = 0;
    int m_base = 0, m_n = 0, m_len = 1;
    bit m_ilv = 0;

    function automatic int code_len(input logic [2:0] c);
        case (c)
            3'b001:  return 2;
            3'b010:  return 4;
            3'b011:  return 8;
            3'b111:  return 0;
            default: return 1;
        endcase
    endfunction

    function automatic int exp_col(input int base, input int n, input int len, input bit il);
        int lo, blk;
        if (len == 0) return (base + n) % PAGE;
        lo  = base % len;
        blk = base - lo;
        if (il) return blk + (lo ^ n);
        return blk + ((lo + n) % len);
    endfunction

    task automatic step(input logic s, input int c, input logic [2:0] code, input logic il,
                        input logic w, input logic sw, input logic bs, input logic pt,
                        input logic e, input string tag);
        exp_t x;
        @(negedge clk);
        start = s; start_col = c[COL_W-1:0]; bl_code = code; ilv_mode = il;
        start_wr = w; single_wr = sw; burst_stop = bs; pre_term = pt; ce = e;
        if (e) begin
            if (s) begin
                m_act = 1; m_base = c % PAGE; m_n = 0;
                m_len = (w && sw) ? 1 : code_len(code);
                m_ilv = il && (m_len != 0);
            end else if (bs || pt) begin
                m_act = 0;
            end else if (m_act) begin
                if (m_len != 0 && m_n == m_len - 1) m_act = 0;
                else m_n++;
            end
        end
        x.valid = m_act;
        x.last  = m_act && m_len != 0 && m_n == m_len - 1;
        x.col   = exp_col(m_base, m_n, m_len, m_ilv);
        exp_q.push_back(x);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(0, 0, 3'b000, 0, 0, 0, 0, 0, 1, tag);
    endtask

    task automatic go(input int c, input logic [2:0] code, input logic il, input string tag);
        step(1, c, code, il, 0, 0, 0, 0, 1, tag);
    endtask

    // monitor / scoreboard
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t  x;
            string t;
            x = exp_q.pop_front();
            t = tag_q.pop_front();
            n_chk++;
            if (col_valid !== x.valid || col_last !== x.last ||
                (x.valid && col_addr !== x.col)) begin
                n_bad++;
                $display("FAIL %s: valid/last/col got %0b/%0b/%0d expected %0b/%0b/%0d",
                         t, col_valid, col_last, col_addr, x.valid, x.last, x.col);
            end
        end
    end

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        n_chk++;
        if (col_valid !== 1'b0 || col_last !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: valid/last got %0b/%0b expected 0/0", col_valid, col_last);
        end
        idle(2, "R1");

        // R2 R3 R4: sequential four-beat from column 6 -> 6,7,4,5
        go(6, 3'b010, 0, "R2");
        idle(5, "R4");
        // R4: eight-beat sequential keeps upper bits
        go(45, 3'b011, 0, "R4");
        idle(9, "R4");
        // R5: interleaved eight-beat from 5 -> 5,4,7,6,1,0,3,2
        go(5, 3'b011, 1, "R5");
        idle(9, "R5");
        go(18, 3'b010, 1, "R5");
        idle(5, "R5");
        go(3, 3'b001, 1, "R5");
        idle(3, "R5");
        // R3: lengths one and two, reserved code as one beat
        go(9, 3'b000, 0, "R3");
        idle(2, "R3");
        go(9, 3'b001, 0, "R3");
        idle(3, "R3");
        go(20, 3'b101, 1, "R3");
        idle(2, "R3");
        // R6: full page across the page end, interleave ignored
        go(58, 3'b111, 1, "R6");
        idle(70, "R6");
        // R7: stop and precharge termination
        step(0, 0, 3'b000, 0, 0, 0, 1, 0, 1, "R7");
        idle(2, "R7");
        go(30, 3'b111, 0, "R7");
        idle(4, "R7");
        step(0, 0, 3'b000, 0, 0, 0, 0, 1, 1, "R7");
        idle(2, "R7");
        go(12, 3'b011, 0, "R7");
        idle(2, "R7");
        step(0, 0, 3'b000, 0, 0, 0, 1, 1, 1, "R7");
        idle(2, "R7");
        // R8: restart mid-burst, start beats stop in same cycle
        go(16, 3'b011, 0, "R8");
        idle(3, "R8");
        go(41, 3'b010, 1, "R8");
        idle(1, "R8");
        step(1, 50, 3'b001, 0, 0, 0, 1, 1, 1, "R8");
        idle(3, "R8");
        // R9: single-write option
        step(1, 22, 3'b011, 0, 1, 1, 0, 0, 1, "R9");
        idle(3, "R9");
        step(1, 22, 3'b011, 0, 1, 0, 0, 0, 1, "R9");
        idle(9, "R9");
        step(1, 26, 3'b010, 1, 0, 1, 0, 0, 1, "R9");
        idle(5, "R9");
        step(1, 40, 3'b111, 0, 1, 1, 0, 0, 1, "R9");
        idle(2, "R9");
        // R10: clock enable low freezes, even with start and stop offered
        go(33, 3'b011, 0, "R10");
        idle(2, "R10");
        step(1, 7, 3'b000, 0, 0, 0, 0, 0, 0, "R10");
        step(0, 0, 3'b000, 0, 0, 0, 1, 1, 0, "R10");
        step(0, 0, 3'b000, 0, 0, 0, 0, 0, 0, "R10");
        idle(8, "R10");

        @(negedge clk);
        @(negedge clk);
        finish_run();
    end
endmodule